// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps a small set of binary lock flags, eight by default, that two independent ports share. Each port addresses one flag through the low bits of its address bus and claims the flag by writing a 0 in data bit 0. It gives the flag up by writing a 1. A later read tells the port whether it now holds that flag. Software on each side therefore runs a write-then-read sequence to take a shared resource, and the hardware makes sure that only one side ever holds a given flag.

A claim made while the other side holds the flag is not lost. It stays in that side's own request latch. When the holder releases, the flag passes straight to the waiting side on the same clock edge, and the waiting side needs no second write. When both sides claim a free flag in the same cycle, the left side gets it and the right side's claim waits.

A read drives the flag state onto every data bit and freezes it. The value stays put for as long as that port keeps its select and output enable active with write low, so a poll must end one access before it starts the next. All state is clocked, and reset leaves every flag free with no requests pending.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset, a read of any flag from either side returns all ones (8'hFF with the default data width).
- R2: The flag is chosen by address bits [2:0] only. Accesses whose upper address bits differ but whose low three bits match reach the same flag.
- R3: On a write, only data bit 0 matters: 0 requests the flag and 1 releases it. The value of bits [7:1] has no effect.
- R4: When a side writes 0 to a free flag, that side then reads 8'h00 and the other side reads 8'hFF.
- R5: When a side writes 0 to a flag the other side holds, the request stays pending and that side keeps reading 8'hFF. On the clock edge where the holder writes 1, the flag passes to the waiting side: it then reads 8'h00 and the former holder reads 8'hFF.
- R6: When a flag has been released and no request is pending, both sides read 8'hFF.
- R7: Every read returns the flag value copied onto all data bits: 8'h00 means held by the reading side and 8'hFF means not held by it.
- R8: A read is active while select and output enable are high and write enable is low. The read data is captured on the first clock edge of that read and does not change until the read ends, even if the flag changes hands in the meantime. A fresh read shows the new state.
- R9: When both sides write 0 to the same free flag in the same cycle, the left side receives it and the right side's request stays pending. The right side obtains the flag when the left side releases it.
- R10: When a side with a pending request writes 1, it withdraws that request without disturbing the current holder. A later release by the holder then leaves the flag free.
- R11: A write with select low changes no flag, and a cycle with no write on either side changes no flag state.
- R12: The flags are independent: an access to one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_we | input | 1 | Left write enable (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | ADDR_W (15) | Left address; only the low flag-index bits are decoded |
| l_wdata | input | DATA_W (8) | Left write data; bit 0 is the request value |
| l_rdata | output | DATA_W (8) | Left read data, flag value copied onto all bits |
| r_sel | input | 1 | Right semaphore select, active high |
| r_we | input | 1 | Right write enable (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | ADDR_W (15) | Right address; only the low flag-index bits are decoded |
| r_wdata | input | DATA_W (8) | Right write data; bit 0 is the request value |
| r_rdata | output | DATA_W (8) | Right read data, flag value copied onto all bits |

## Verification
Corrupt ownership or request-latch state is visible at the ports only through a read, and only once a new read has begun. The frozen read value can therefore hide a fault until the polling side ends its access and starts another, one idle cycle later. A lost pending request shows up when the holder releases and the waiting side's next read returns 8'hFF instead of 8'h00. A wrong tie-break or a double grant shows up on the first reads from both sides after a same-cycle claim. For these reasons the bench follows each write with reads from both sides and uses the freeze scenario to check that a handover made during a read stays hidden until the next read.

// File: rtl/sem_pkg.sv
package sem_pkg;

   // Who currently holds a flag
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sem_owner_e;

endpackage

// File: rtl/sem_port_dec.sv
// Per-port decode: turns one port's controls into per-flag request and
// release strobes plus a read-active indication.
module sem_port_dec #(
   parameter int NUM_FLAGS = 8,
   localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
   input  logic                 sel,
   input  logic                 we,
   input  logic                 oe,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 wbit,
   output logic [NUM_FLAGS-1:0] req_stb,
   output logic [NUM_FLAGS-1:0] rel_stb,
   output logic                 rd_act
);

   logic wr_act;

   assign wr_act = sel & we;
   assign rd_act = sel & oe & ~we;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic hit;
      assign hit        = wr_act && (idx == IDX_W'(g));
      assign req_stb[g] = hit & ~wbit;
      assign rel_stb[g] = hit &  wbit;
   end

endmodule

// File: rtl/sem_flag_cell.sv
// One semaphore flag: a request latch per side plus the owner register.
module sem_flag_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic held_l,
   output logic held_r,
   output logic want_l,
   output logic want_r
);

   logic       want_l_q, want_r_q;
   logic       want_l_nx, want_r_nx;
   sem_owner_e owner_q, owner_nx;

   // Request latch update: a 0 write sets the request, a 1 write clears it
   always_comb begin
      want_l_nx = want_l_q;
      if (l_req)      want_l_nx = 1'b1;
      else if (l_rel) want_l_nx = 1'b0;
      want_r_nx = want_r_q;
      if (r_req)      want_r_nx = 1'b1;
      else if (r_rel) want_r_nx = 1'b0;
   end

   // Ownership: the left side wins a tie on a free flag, a release hands
   // the flag to a pending request on the other side on the same edge
   always_comb begin
      owner_nx = owner_q;
      unique case (owner_q)
         OWN_NONE: begin
            if (want_l_nx)      owner_nx = OWN_LEFT;
            else if (want_r_nx) owner_nx = OWN_RIGHT;
         end
         OWN_LEFT: begin
            if (!want_l_nx) owner_nx = want_r_nx ? OWN_RIGHT : OWN_NONE;
         end
         OWN_RIGHT: begin
            if (!want_r_nx) owner_nx = want_l_nx ? OWN_LEFT : OWN_NONE;
         end
         default: owner_nx = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_l_q <= 1'b0;
         want_r_q <= 1'b0;
         owner_q  <= OWN_NONE;
      end else begin
         want_l_q <= want_l_nx;
         want_r_q <= want_r_nx;
         owner_q  <= owner_nx;
      end
   end

   assign held_l = (owner_q == OWN_LEFT);
   assign held_r = (owner_q == OWN_RIGHT);
   assign want_l = want_l_q;
   assign want_r = want_r_q;

endmodule

// File: rtl/sem_read_latch.sv
// Per-port read register: captures the flag on the first edge of a read
// and holds it until the read ends.
module sem_read_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              flag_bit,
   output logic [DATA_W-1:0] rdata
);

   logic              rd_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q    <= 1'b0;
         rdata_q <= '1;
      end else begin
         rd_q <= rd_act;
         if (rd_act && !rd_q)
            rdata_q <= {DATA_W{flag_bit}};
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/sem_flag_bank.sv
// Two-port bank of binary semaphore flags.
module sem_flag_bank #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_we,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel,
   input  logic              r_we,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int IDX_W = $clog2(NUM_FLAGS);

   // Elaboration-time parameter checks
   if (NUM_FLAGS < 2 || (1 << IDX_W) != NUM_FLAGS) begin : g_bad_flags
      $error("NUM_FLAGS must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W must cover the flag index");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [IDX_W-1:0]     l_idx, r_idx;
   logic [NUM_FLAGS-1:0] l_req_v, l_rel_v, r_req_v, r_rel_v;
   logic                 l_rd_act, r_rd_act;
   logic [NUM_FLAGS-1:0] held_l_vec, held_r_vec, want_l_vec, want_r_vec;
   logic                 l_flag, r_flag;

   assign l_idx = l_addr[IDX_W-1:0];
   assign r_idx = r_addr[IDX_W-1:0];

   sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
      .sel     (l_sel),
      .we      (l_we),
      .oe      (l_oe),
      .idx     (l_idx),
      .wbit    (l_wdata[0]),
      .req_stb (l_req_v),
      .rel_stb (l_rel_v),
      .rd_act  (l_rd_act)
   );

   sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
      .sel     (r_sel),
      .we      (r_we),
      .oe      (r_oe),
      .idx     (r_idx),
      .wbit    (r_wdata[0]),
      .req_stb (r_req_v),
      .rel_stb (r_rel_v),
      .rd_act  (r_rd_act)
   );

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
      sem_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_req  (l_req_v[g]),
         .l_rel  (l_rel_v[g]),
         .r_req  (r_req_v[g]),
         .r_rel  (r_rel_v[g]),
         .held_l (held_l_vec[g]),
         .held_r (held_r_vec[g]),
         .want_l (want_l_vec[g]),
         .want_r (want_r_vec[g])
      );
   end

   // Flag value seen by a side: 0 when that side holds it
   assign l_flag = ~held_l_vec[l_idx];
   assign r_flag = ~held_r_vec[r_idx];

   sem_read_latch #(.DATA_W(DATA_W)) u_rd_l (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (l_rd_act),
      .flag_bit (l_flag),
      .rdata    (l_rdata)
   );

   sem_read_latch #(.DATA_W(DATA_W)) u_rd_r (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (r_rd_act),
      .flag_bit (r_flag),
      .rdata    (r_rdata)
   );

endmodule

// File: rtl/sem_flag_bank_chk.sv
// Property checker bound to the semaphore bank.
module sem_flag_bank_chk #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 l_sel,
   input logic                 l_we,
   input logic                 l_oe,
   input logic [ADDR_W-1:0]    l_addr,
   input logic [DATA_W-1:0]    l_wdata,
   input logic [DATA_W-1:0]    l_rdata,
   input logic                 r_sel,
   input logic                 r_we,
   input logic                 r_oe,
   input logic [ADDR_W-1:0]    r_addr,
   input logic [DATA_W-1:0]    r_wdata,
   input logic [DATA_W-1:0]    r_rdata,
   input logic [NUM_FLAGS-1:0] held_l,
   input logic [NUM_FLAGS-1:0] held_r,
   input logic [NUM_FLAGS-1:0] want_l,
   input logic [NUM_FLAGS-1:0] want_r
);

   logic l_rd, r_rd, l_wr, r_wr;
   assign l_rd = l_sel && l_oe && !l_we;
   assign r_rd = r_sel && r_oe && !r_we;
   assign l_wr = l_sel && l_we;
   assign r_wr = r_sel && r_we;

   AST_LEFT_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd && $past(l_rd) && $past(l_rd, 2)) |-> $stable(l_rdata)); // R8
   AST_RIGHT_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rd && $past(r_rd) && $past(r_rd, 2)) |-> $stable(r_rdata)); // R8

   AST_READ_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1)); // R7

   AST_HOLDER_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      ((held_l & ~want_l) == '0) && ((held_r & ~want_r) == '0)); // R5

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_wr && !r_wr) |=> ($stable(held_l) && $stable(held_r) &&
                            $stable(want_l) && $stable(want_r))); // R11

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic l_hit, r_hit;
      assign l_hit = l_wr && (l_addr[IDX_W-1:0] == IDX_W'(g));
      assign r_hit = r_wr && (r_addr[IDX_W-1:0] == IDX_W'(g));

      AST_HANDOVER_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
         (l_hit && l_wdata[0] && held_l[g] && want_r[g] && !r_hit) |=> held_r[g]); // R5
      AST_HANDOVER_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
         (r_hit && r_wdata[0] && held_r[g] && want_l[g] && !l_hit) |=> held_l[g]); // R5
      AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
         (l_hit && !l_wdata[0] && r_hit && !r_wdata[0] &&
          !held_l[g] && !held_r[g] && !want_l[g] && !want_r[g])
         |=> (held_l[g] && want_r[g])); // R9
   end

endmodule

bind sem_flag_bank sem_flag_bank_chk #(
   .NUM_FLAGS (NUM_FLAGS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .l_sel   (l_sel),
   .l_we    (l_we),
   .l_oe    (l_oe),
   .l_addr  (l_addr),
   .l_wdata (l_wdata),
   .l_rdata (l_rdata),
   .r_sel   (r_sel),
   .r_we    (r_we),
   .r_oe    (r_oe),
   .r_addr  (r_addr),
   .r_wdata (r_wdata),
   .r_rdata (r_rdata),
   .held_l  (held_l_vec),
   .held_r  (held_r_vec),
   .want_l  (want_l_vec),
   .want_r  (want_r_vec)
);

// File: tb/sem_flag_bank_bench.sv
module sem_flag_bank_bench;

   localparam int ADDR_W = 15;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              l_sel = 0, l_we = 0, l_oe = 0;
   logic [ADDR_W-1:0] l_addr = '0;
   logic [DATA_W-1:0] l_wdata = '0;
   logic [DATA_W-1:0] l_rdata;
   logic              r_sel = 0, r_we = 0, r_oe = 0;
   logic [ADDR_W-1:0] r_addr = '0;
   logic [DATA_W-1:0] r_wdata = '0;
   logic [DATA_W-1:0] r_rdata;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   localparam logic [DATA_W-1:0] FREE = 8'hFF;
   localparam logic [DATA_W-1:0] MINE = 8'h00;

   always #2 clk = ~clk;  // 250 MHz

   sem_flag_bank #(.NUM_FLAGS(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_flag_bank (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   task automatic check(input string tag, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // side 0 = left, 1 = right
   task automatic wr(input bit side, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
      @(negedge clk);
      if (!side) begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
      else       begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
      @(negedge clk);
      l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
   endtask

   task automatic rd(input bit side, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] exp, input string tag);
      logic [DATA_W-1:0] got;
      @(negedge clk);
      if (!side) begin l_sel = 1; l_oe = 1; l_we = 0; l_addr = a; end
      else       begin r_sel = 1; r_oe = 1; r_we = 0; r_addr = a; end
      @(negedge clk);
      got = side ? r_rdata : l_rdata;
      l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
      @(negedge clk);
      check(tag, got, exp);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) begin
         rd(0, ADDR_W'(i), FREE, "R1 left after reset");
         rd(1, ADDR_W'(i), FREE, "R1 right after reset");
      end
   endtask

   task automatic t_claim;
      wr(0, 3, 8'h00);
      rd(0, 3, MINE, "R4 R7 left claims flag3");
      rd(1, 3, FREE, "R4 R7 right sees flag3 taken");
      wr(0, 3, 8'h01);
      rd(1, 3, FREE, "R6 flag3 released right");
      rd(0, 3, FREE, "R6 flag3 released left");
   endtask

   task automatic t_alias;
      wr(1, 15'h7FF9, 8'h00);            // index 1
      rd(1, 15'h0001, MINE, "R2 right alias of flag1");
      rd(0, 15'h1239, FREE, "R2 left alias of flag1");
      rd(1, 15'h0000, FREE, "R12 flag0 untouched");
      rd(0, 15'h0002, FREE, "R12 flag2 untouched");
      wr(1, 15'h4001, 8'hFF);
      rd(1, 15'h0001, FREE, "R2 release through other alias");
   endtask

   task automatic t_databits;
      wr(0, 5, 8'hFE);
      rd(0, 5, MINE, "R3 bit0 zero requests");
      wr(0, 5, 8'h01);
      rd(0, 5, FREE, "R3 bit0 one releases");
      rd(1, 5, FREE, "R6 flag5 free right");
   endtask

   task automatic t_queue;
      wr(0, 6, 8'h00);
      wr(1, 6, 8'h00);
      rd(1, 6, FREE, "R5 right request pending");
      rd(0, 6, MINE, "R5 left keeps flag6");
      wr(0, 6, 8'h01);
      rd(1, 6, MINE, "R5 right granted on release");
      rd(0, 6, FREE, "R5 left no longer holds");
      wr(1, 6, 8'h01);
      rd(0, 6, FREE, "R6 flag6 free left");
      rd(1, 6, FREE, "R6 flag6 free right");
   endtask

   task automatic t_freeze;
      wr(1, 2, 8'h00);
      wr(0, 2, 8'h00);                   // left pending
      @(negedge clk);
      l_sel = 1; l_oe = 1; l_we = 0; l_addr = 2;
      @(negedge clk);
      check("R8 read captures taken state", l_rdata, FREE);
      r_sel = 1; r_we = 1; r_addr = 2; r_wdata = 8'h01;
      @(negedge clk);
      r_sel = 0; r_we = 0;
      check("R8 held across handover", l_rdata, FREE);
      @(negedge clk);
      check("R8 still held", l_rdata, FREE);
      l_sel = 0; l_oe = 0;
      @(negedge clk);
      rd(0, 2, MINE, "R8 R5 fresh read after handover");
      wr(0, 2, 8'h01);
   endtask

   task automatic t_simul;
      @(negedge clk);
      l_sel = 1; l_we = 1; l_addr = 4; l_wdata = 8'h00;
      r_sel = 1; r_we = 1; r_addr = 4; r_wdata = 8'h00;
      @(negedge clk);
      l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
      rd(0, 4, MINE, "R9 tie goes left");
      rd(1, 4, FREE, "R9 right waits");
      wr(0, 4, 8'h01);
      rd(1, 4, MINE, "R9 right gets it after left release");
      wr(1, 4, 8'h01);
      rd(0, 4, FREE, "R9 flag4 free afterwards");
   endtask

   task automatic t_withdraw;
      wr(0, 7, 8'h00);
      wr(1, 7, 8'h00);
      wr(1, 7, 8'h01);                   // withdraw pending request
      rd(0, 7, MINE, "R10 holder unaffected by withdraw");
      wr(0, 7, 8'h01);
      rd(1, 7, FREE, "R10 no grant after withdraw");
      rd(0, 7, FREE, "R10 flag7 free");
   endtask

   task automatic t_nosel;
      @(negedge clk);
      l_sel = 0; l_we = 1; l_addr = 0; l_wdata = 8'h00;
      @(negedge clk);
      l_we = 0;
      rd(0, 0, FREE, "R11 unselected write ignored left");
      rd(1, 0, FREE, "R11 unselected write ignored right");
      wr(1, 0, 8'h00);
      repeat (3) @(negedge clk);
      rd(1, 0, MINE, "R11 idle cycles keep holder");
      wr(1, 0, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_claim;
      t_alias;
      t_databits;
      t_queue;
      t_freeze;
      t_simul;
      t_withdraw;
      t_nosel;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule